// File: doc/BRIEF.md
# Soft-Switching Gate Pair Generator

This block turns the single PWM gate command of a power factor controller into two gate commands for a resonant soft-switching boost cell. One goes to the main switch and one to the auxiliary switch. The main gate follows the controller pulse and is then held on for a programmable overlap. The auxiliary gate is fired at the start of that overlap, so the resonant tank can pull the main switch current to zero before the main gate is removed. All timing is counted in cycles of a fast system clock.

Every main pulse is shaped so that the turn-on resonance always completes, because a pulse is never shorter than a minimum on-time. Enough off-time is also left for the turn-off resonance, because the on-time is capped at a fixed fraction of the switching period. A new controller pulse is held back until the auxiliary pulse has finished. The overlap and the auxiliary length are inputs, and they are checked against each other continuously. The minimum on-time, the period and the duty fraction are parameters.

Top module: `zcs_gate_pair`

## Requirements
- R1: `pwm_in` passes through a two-stage synchroniser. If `pwm_in` is first sampled high at rising edge N, with the block idle and enabled, `gate_main` goes high at edge N+2.
- R2: Let W be the number of consecutive edges that sample `pwm_in` high, and S the value of `stretch_cyc`. Then `gate_main` stays high for min(max(W+S, MIN_ON_CYC), MAX_ON) cycles.
- R3: `gate_aux` rises exactly S cycles before `gate_main` falls, so both gates are high during the last S cycles of every main pulse.
- R4: Once risen, `gate_aux` stays high for exactly `aux_cyc` cycles.
- R5: MAX_ON = floor(PERIOD_CYC*DUTY_NUM/DUTY_DEN). A pulse cut at that limit still gets its auxiliary pulse per R3. Input high time after the cut is ignored until the next rising edge of `pwm_in`.
- R6: A rising edge of `pwm_in` that is detected while a main or auxiliary pulse is in progress is remembered. The main gate then rises on the edge after `gate_aux` falls, provided the synchronised input is still high. W in R2 is then counted from that edge.
- R7: A remembered rising edge is dropped if the synchronised input goes low before it can start. No main pulse follows it.
- R8: `config_error` is high, combinationally, whenever S = 0, or `aux_cyc` <= S, or S >= MAX_ON. While it is high, both gates are driven low from the next edge on.
- R9: `rst` (synchronous) or a low `en` drives both gates low at the next edge. After reset both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; low forces both gates off |
| pwm_in | input | 1 | Asynchronous gate command from the PWM controller |
| stretch_cyc | input | CW | Overlap length S in cycles |
| aux_cyc | input | CW | Auxiliary pulse length in cycles |
| gate_main | output | 1 | Main switch gate command |
| gate_aux | output | 1 | Auxiliary switch gate command |
| config_error | output | 1 | Overlap/auxiliary setting is illegal |

## Verification
The hardest situation to reach is a new controller pulse arriving while the previous turn-off sequence is still running. The remembered edge must then either wait for the auxiliary pulse to end or be dropped. The stimulus creates this with a short first pulse followed by a gap of only two cycles, so the second rising edge is detected during the overlap. One variant keeps the second pulse high past the end of the auxiliary pulse. The other lets it end first. Expected edge times for both come from the R2 formula, with W counted from the deferred start.

// File: rtl/zcs_gate_pkg.sv
package zcs_gate_pkg;

  typedef enum logic [1:0] {
    MS_IDLE    = 2'd0,
    MS_CONDUCT = 2'd1,
    MS_OVERLAP = 2'd2
  } main_state_e;

  function automatic int unsigned duty_cap(input int unsigned period,
                                           input int unsigned num,
                                           input int unsigned den);
    return (period * num) / den;
  endfunction

endpackage

// File: rtl/zcs_in_sync.sv
module zcs_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic lvl,
  output logic rise
);
  // STAGES synchroniser flops plus one history flop for the edge detect
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/zcs_aux_timer.sv
module zcs_aux_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          fire,
  input  logic [CW-1:0] len,
  output logic          gate_aux
);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      gate_aux <= 1'b0;
      left     <= '0;
    end else if (fire) begin
      gate_aux <= 1'b1;
      left     <= len;
    end else if (gate_aux) begin
      if (left == CW'(1)) gate_aux <= 1'b0;
      left <= left - CW'(1);
    end
  end
endmodule

// File: rtl/zcs_main_seq.sv
module zcs_main_seq
  import zcs_gate_pkg::*;
#(
  parameter int CW     = 8,
  parameter int OW     = 11,
  parameter int MIN_ON = 150,
  parameter int MAX_ON = 1363
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          lvl,
  input  logic          rise,
  input  logic          aux_busy,
  input  logic [CW-1:0] stretch,
  output logic          gate_main,
  output logic          commit
);
  localparam int SW = ((OW > CW) ? OW : CW) + 1;

  main_state_e   st;
  logic [OW-1:0] on_cnt;
  logic [CW-1:0] ovl_left;
  logic          pend;

  // projected main high time if the turn-off sequence starts now
  logic [SW-1:0] reach;
  logic          min_met, cap_hit, start;

  assign reach   = SW'(on_cnt) + SW'(stretch);
  assign min_met = reach >= SW'(MIN_ON);
  assign cap_hit = reach >= SW'(MAX_ON);
  assign commit  = (st == MS_CONDUCT) && min_met && (!lvl || cap_hit);
  assign start   = (st == MS_IDLE) && (rise || pend) && lvl && !aux_busy;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st        <= MS_IDLE;
      on_cnt    <= '0;
      ovl_left  <= '0;
      pend      <= 1'b0;
      gate_main <= 1'b0;
    end else begin
      if (!lvl || start) pend <= 1'b0;
      else if (rise)     pend <= 1'b1;
      unique case (st)
        MS_IDLE: begin
          if (start) begin
            st        <= MS_CONDUCT;
            gate_main <= 1'b1;
            on_cnt    <= OW'(1);
          end
        end
        MS_CONDUCT: begin
          on_cnt <= on_cnt + OW'(1);
          if (commit) begin
            st       <= MS_OVERLAP;
            ovl_left <= stretch;
          end
        end
        MS_OVERLAP: begin
          on_cnt <= on_cnt + OW'(1);
          if (ovl_left == CW'(1)) begin
            st        <= MS_IDLE;
            gate_main <= 1'b0;
          end else begin
            ovl_left <= ovl_left - CW'(1);
          end
        end
        default: st <= MS_IDLE;
      endcase
    end
  end

  // R6: a main pulse never begins while the auxiliary gate is still on
  a_r6_start_after_aux: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_main) |-> !$past(aux_busy));
endmodule

// File: rtl/zcs_gate_pair.sv
module zcs_gate_pair
  import zcs_gate_pkg::*;
#(
  parameter int CW          = 8,
  parameter int PERIOD_CYC  = 1515,
  parameter int DUTY_NUM    = 9,
  parameter int DUTY_DEN    = 10,
  parameter int MIN_ON_CYC  = 150,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          pwm_in,
  input  logic [CW-1:0] stretch_cyc,
  input  logic [CW-1:0] aux_cyc,
  output logic          gate_main,
  output logic          gate_aux,
  output logic          config_error
);
  localparam int          MAX_ON   = int'(duty_cap(PERIOD_CYC, DUTY_NUM, DUTY_DEN));
  localparam int          OW       = $clog2(PERIOD_CYC + 1);
  localparam logic [31:0] MAX_ON_W = 32'(MAX_ON);

  logic lvl, rise, commit, run;

  assign config_error = (stretch_cyc == '0) || (aux_cyc <= stretch_cyc) ||
                        (32'(stretch_cyc) >= MAX_ON_W);
  assign run = en && !config_error;

  zcs_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pwm_in), .lvl(lvl), .rise(rise)
  );

  zcs_main_seq #(.CW(CW), .OW(OW), .MIN_ON(MIN_ON_CYC), .MAX_ON(MAX_ON)) u_main (
    .clk(clk), .rst(rst), .run(run), .lvl(lvl), .rise(rise),
    .aux_busy(gate_aux), .stretch(stretch_cyc),
    .gate_main(gate_main), .commit(commit)
  );

  zcs_aux_timer #(.CW(CW)) u_aux (
    .clk(clk), .rst(rst), .run(run), .fire(commit), .len(aux_cyc),
    .gate_aux(gate_aux)
  );

  // length of the current main high run, for the duty cap check
  logic [OW:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst || !gate_main) hi_run <= '0;
    else                   hi_run <= hi_run + (OW+1)'(1);
  end

  a_r5_duty_cap: assert property (@(posedge clk) disable iff (rst)
    gate_main |-> (hi_run < (OW+1)'(MAX_ON)));

  a_r3_aux_covers_fall: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_main) && $past(run)) |-> gate_aux);

  a_r3_aux_under_main: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_aux) |-> gate_main);

  a_r8_cfg_gates_low: assert property (@(posedge clk) disable iff (rst)
    config_error |=> (!gate_main && !gate_aux));

  a_r9_disable_gates_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!gate_main && !gate_aux));
endmodule

// File: tb/sim_zcs_gate_pair.sv
module sim_zcs_gate_pair;
  localparam int CW    = 8;
  localparam int PER   = 20;
  localparam int DN    = 9;
  localparam int DD    = 10;
  localparam int MINON = 6;
  localparam int MAXON = PER * DN / DD;

  logic clk = 1'b0, rst = 1'b1, en = 1'b1, pwm = 1'b0;
  logic [CW-1:0] s_cyc = 8'd2, a_cyc = 8'd4;
  logic gm, ga, ce;

  int cyc = 0, n_chk = 0, n_bad = 0;
  int mr, mf, ar, af, nmr;
  logic pm = 1'b0, pa = 1'b0;

  zcs_gate_pair #(.CW(CW), .PERIOD_CYC(PER), .DUTY_NUM(DN), .DUTY_DEN(DD),
                  .MIN_ON_CYC(MINON), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .en(en), .pwm_in(pwm),
    .stretch_cyc(s_cyc), .aux_cyc(a_cyc),
    .gate_main(gm), .gate_aux(ga), .config_error(ce)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (gm && !pm) begin mr = cyc; nmr = nmr + 1; end
    if (!gm && pm) mf = cyc;
    if (ga && !pa) ar = cyc;
    if (!ga && pa) af = cyc;
    pm = gm;
    pa = ga;
  end

  function automatic int exp_len(input int w, input int s);
    int l;
    l = w + s;
    if (l < MINON) l = MINON;
    if (l > MAXON) l = MAXON;
    return l;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_rec();
    mr = -1; mf = -1; ar = -1; af = -1; nmr = 0;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int w, output int p);
    p = cyc;
    pwm = 1'b1;
    hold(w);
    pwm = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p, l, es, wr;
    clear_rec();
    @(negedge clk);
    hold(3);
    chk("R9", "main low in reset", int'(gm), 0);
    chk("R9", "aux low in reset", int'(ga), 0);
    rst = 1'b0;
    hold(3);
    chk("R9", "main low after reset", int'(gm), 0);
    chk("R9", "aux low after reset", int'(ga), 0);

    // R8: legality of overlap/aux settings
    for (int s = 0; s <= 4; s++) begin
      for (int a = 0; a <= 5; a++) begin
        s_cyc = CW'(s); a_cyc = CW'(a);
        #1;
        chk("R8", "config_error", int'(ce), (s == 0 || a <= s) ? 1 : 0);
      end
    end
    s_cyc = CW'(MAXON); a_cyc = CW'(MAXON + 2); #1;
    chk("R8", "config_error at cap", int'(ce), 1);
    s_cyc = CW'(MAXON - 1); #1;
    chk("R8", "config_error below cap", int'(ce), 0);
    @(negedge clk);

    // R8: illegal setting keeps gates off
    s_cyc = 8'd3; a_cyc = 8'd3;
    hold(2);
    clear_rec();
    pulse(8, p);
    hold(40);
    chk("R8", "main pulses under config error", nmr, 0);
    chk("R8", "aux rise under config error", ar, -1);

    // R1..R5 sweep
    for (int s = 1; s <= 3; s++) begin
      for (int a = s + 1; a <= s + 2; a++) begin
        s_cyc = CW'(s); a_cyc = CW'(a);
        hold(3);
        chk("R8", "legal config_error", int'(ce), 0);
        for (int w = 1; w <= 22; w++) begin
          clear_rec();
          pulse(w, p);
          hold(45);
          l = exp_len(w, s);
          chk("R1", "main rise cycle", mr, p + 3);
          chk((w + s >= MAXON) ? "R5" : "R2", "main length", mf - mr, l);
          chk((w + s >= MAXON) ? "R5" : "R2", "main pulse count", nmr, 1);
          chk("R3", "aux lead before main fall", mf - ar, s);
          chk("R4", "aux length", af - ar, a);
        end
      end
    end

    // R6: rising edge during overlap is deferred past the aux pulse
    s_cyc = 8'd2; a_cyc = 8'd8;
    hold(3);
    clear_rec();
    pulse(3, p);
    hold(2);
    pwm = 1'b1;
    hold(10);
    pwm = 1'b0;
    hold(50);
    es = (p + 3 + exp_len(3, 2)) - 2 + 8 + 1;
    wr = (p + 5 + 3 + 10) - es;
    l  = exp_len(wr, 2);
    chk("R6", "deferred pulse count", nmr, 2);
    chk("R6", "deferred main rise", mr, es);
    chk("R6", "deferred main length", mf - mr, l);
    chk("R6", "deferred aux lead", mf - ar, 2);

    // R7: remembered edge dropped when input ends first
    clear_rec();
    pulse(3, p);
    hold(2);
    pwm = 1'b1;
    hold(3);
    pwm = 1'b0;
    hold(50);
    chk("R7", "dropped pulse count", nmr, 1);
    chk("R7", "first main fall", mf, p + 3 + exp_len(3, 2));

    // R9: enable low cuts the gates at the next edge
    s_cyc = 8'd2; a_cyc = 8'd4;
    hold(3);
    clear_rec();
    p = cyc;
    pwm = 1'b1;
    hold(5);
    chk("R9", "main high before disable", int'(gm), 1);
    en = 1'b0;
    hold(1);
    chk("R9", "main low after disable", int'(gm), 0);
    chk("R9", "aux low after disable", int'(ga), 0);
    hold(9);
    pwm = 1'b0;
    hold(5);
    en = 1'b1;
    hold(30);
    chk("R9", "no pulse after re-enable", nmr, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule